// File: doc/BRIEF.md
# Requester-ID to StreamID Lookup Table

This block translates the 16-bit Requester ID carried by an inbound PCIe transaction into the 6-bit StreamID that an IOMMU and an MSI controller use to tell traffic sources apart. A StreamID has only six bits, so Requester IDs cannot be passed through one to one. Instead, the block holds a small table of programmable entries. Each entry holds a reference Requester ID, a per-bit compare mask, a StreamID, a 3-bit controller tag and a valid flag.

Software reaches the table indirectly through three 32-bit registers: a command register and two staging registers. To add an entry, software fills the staging registers and then writes the command register with the target slot and the operation bit clear. Writing the command register with the operation bit set copies a slot back into the staging registers, where software can read it. To remove an entry, software commits zeros to its slot.

A separate lookup port takes one Requester ID per cycle and returns, one cycle later, the StreamID and controller tag of the lowest-numbered matching valid entry, together with a hit flag. A second output places a fixed 2-bit source tag above the StreamID for the MSI path.

Top module: `rid_sid_map`

## Requirements
- R1: After reset every table slot is invalid, the command, staging-1 and staging-2 registers all read zero, and no lookup hits.
- R2: A write to staging-1 (register address 1) keeps only bit 31 (valid), bits 10:8 (controller tag) and bits 5:0 (StreamID); all other bits read back zero. A write to staging-2 (address 2) keeps all 32 bits: bits 31:16 are the reference Requester ID and bits 15:0 are the compare mask.
- R3: A write to the command register (address 0) with bit 16 clear stores the current staging register contents into the slot given by bits 4:0.
- R4: A write to the command register with bit 16 set copies the slot given by bits 4:0 into both staging registers in the same layout. The command register reads back only bits 16 and 4:0 of the value written.
- R5: A lookup hits when a valid slot's reference Requester ID equals the incoming Requester ID on every bit where the mask is one. A hit returns that slot's StreamID and controller tag.
- R6: Requester ID bits whose mask bit is zero do not affect matching, and a mask of all ones requires an exact match.
- R7: When several valid slots match, the lowest-numbered slot supplies the result.
- R8: A lookup that matches no valid slot, and any cycle without a lookup, returns hit low, StreamID zero and controller tag zero.
- R9: Lookup results are registered: the output-valid flag, hit, StreamID and tag appear on the clock edge that samples the lookup request.
- R10: A lookup sampled on the same edge as a commit sees the table as it was before that commit. A lookup on the next edge sees the new entry.
- R11: The MSI output carries the parameter MSI_SRC in bits 7:6 and the StreamID in bits 5:0 on a hit, and is zero otherwise.
- R12: Committing zeros from both staging registers to a slot invalidates it, so its Requester ID no longer hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 command, 1 staging-1, 2 staging-2 |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 2 | Read address, same map |
| reg_rdata | output | 32 | Combinational register read data |
| lk_valid | input | 1 | Lookup request |
| lk_rid | input | 16 | Requester ID to translate |
| lk_out_valid | output | 1 | Lookup result valid, one cycle after request |
| lk_hit | output | 1 | A valid slot matched |
| lk_sid | output | 6 | StreamID of the winning slot |
| lk_cid | output | 3 | Controller tag of the winning slot |
| lk_msi_sid | output | 8 | Source tag above StreamID for the MSI path |

## Verification
Directed lookups probe exact matching with a full mask, don't-care low bits with partial masks, and two overlapping slots whose priority is decided only by slot number. A miss just outside a masked range shows that masked-off bits are ignored while the remaining bits are still compared. A commit and a lookup presented on the same edge separate old-table from new-table visibility. Constrained random programming is then mixed with lookups over a narrow Requester ID range, so that partial masks, invalid slots and overwritten slots collide often. Each result is compared against a bench model that scans the slots from index zero upward.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  localparam int RID_W  = 16;
  localparam int SID_W  = 6;
  localparam int CID_W  = 3;
  localparam int REG_W  = 32;
  localparam int OP_BIT = 16;

  localparam logic [1:0] ADR_CMD = 2'd0;
  localparam logic [1:0] ADR_D1  = 2'd1;
  localparam logic [1:0] ADR_D2  = 2'd2;

  // implemented bits of each register
  localparam logic [REG_W-1:0] CMD_MASK = 32'h0001_001F;
  localparam logic [REG_W-1:0] D1_MASK  = 32'h8000_073F;

  typedef struct packed {
    logic             vld;
    logic [CID_W-1:0] cid;
    logic [SID_W-1:0] sid;
    logic [RID_W-1:0] rid;
    logic [RID_W-1:0] msk;
  } ent_t;

  function automatic logic [REG_W-1:0] ent_to_d1(ent_t e);
    return {e.vld, 20'b0, e.cid, 2'b0, e.sid};
  endfunction

  function automatic logic [REG_W-1:0] ent_to_d2(ent_t e);
    return {e.rid, e.msk};
  endfunction

  function automatic ent_t regs_to_ent(logic [REG_W-1:0] d1, logic [REG_W-1:0] d2);
    ent_t e;
    e.vld = d1[31];
    e.cid = d1[10:8];
    e.sid = d1[5:0];
    e.rid = d2[31:16];
    e.msk = d2[15:0];
    return e;
  endfunction

  // masked compare of one slot against an incoming requester
  function automatic logic ent_match(ent_t e, logic [RID_W-1:0] rid);
    return e.vld && (((rid ^ e.rid) & e.msk) == '0);
  endfunction

  // isolate the lowest set bit
  function automatic logic [63:0] lowest_one(logic [63:0] v);
    return v & (~v + 64'd1);
  endfunction
endpackage

// File: rtl/rsm_regs.sv
module rsm_regs
  import rsm_pkg::*;
#(
  parameter int N_ENT = 32,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  ent_t             rd_ent,
  output logic [IDX_W-1:0] sel_idx,
  output logic             commit,
  output ent_t             commit_ent,
  output logic [REG_W-1:0] cmd_q,
  output logic [REG_W-1:0] d1_q,
  output logic [REG_W-1:0] d2_q
);
  logic cmd_wr;
  logic fetch;

  assign cmd_wr     = reg_we && (reg_addr == ADR_CMD);
  assign sel_idx    = reg_wdata[IDX_W-1:0];
  assign fetch      = cmd_wr && reg_wdata[OP_BIT];
  assign commit     = cmd_wr && !reg_wdata[OP_BIT];
  assign commit_ent = regs_to_ent(d1_q, d2_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      d1_q  <= '0;
      d2_q  <= '0;
    end else begin
      if (cmd_wr) cmd_q <= reg_wdata & CMD_MASK;
      if (fetch) begin
        d1_q <= ent_to_d1(rd_ent);
        d2_q <= ent_to_d2(rd_ent);
      end else if (reg_we && reg_addr == ADR_D1) begin
        d1_q <= reg_wdata & D1_MASK;
      end else if (reg_we && reg_addr == ADR_D2) begin
        d2_q <= reg_wdata;
      end
    end
  end
endmodule

// File: rtl/rsm_store.sv
module rsm_store
  import rsm_pkg::*;
#(
  parameter int N_ENT = 32,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ent_t             wr_ent,
  input  logic [IDX_W-1:0] rd_idx,
  output ent_t             rd_ent,
  output ent_t [N_ENT-1:0] tbl
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl[i] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        tbl[i] <= wr_ent;
      end
    end
  end

  always_comb begin
    rd_ent = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (rd_idx == IDX_W'(i)) rd_ent = tbl[i];
    end
  end
endmodule

// File: rtl/rsm_match.sv
module rsm_match
  import rsm_pkg::*;
#(
  parameter int N_ENT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [RID_W-1:0] lk_rid,
  input  ent_t [N_ENT-1:0] tbl,
  output logic [N_ENT-1:0] win_vec,
  output logic             out_valid,
  output logic             hit,
  output logic [SID_W-1:0] sid,
  output logic [CID_W-1:0] cid
);
  logic [N_ENT-1:0] hit_vec;
  logic [63:0]      win_wide;
  logic [SID_W-1:0] sid_sel;
  logic [CID_W-1:0] cid_sel;

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hit_vec[i] = ent_match(tbl[i], lk_rid);
  end

  assign win_wide = lowest_one(64'(hit_vec));
  assign win_vec  = win_wide[N_ENT-1:0];

  always_comb begin
    sid_sel = '0;
    cid_sel = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (win_vec[i]) begin
        sid_sel = sid_sel | tbl[i].sid;
        cid_sel = cid_sel | tbl[i].cid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      hit       <= 1'b0;
      sid       <= '0;
      cid       <= '0;
    end else begin
      out_valid <= lk_valid;
      hit       <= lk_valid && (hit_vec != '0);
      sid       <= lk_valid ? sid_sel : '0;
      cid       <= lk_valid ? cid_sel : '0;
    end
  end
endmodule

// File: rtl/rid_sid_map.sv
module rid_sid_map
  import rsm_pkg::*;
#(
  parameter int         N_ENT   = 32,
  parameter logic [1:0] MSI_SRC = 2'b01,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  input  logic        lk_valid,
  input  logic [15:0] lk_rid,
  output logic        lk_out_valid,
  output logic        lk_hit,
  output logic [5:0]  lk_sid,
  output logic [2:0]  lk_cid,
  output logic [7:0]  lk_msi_sid
);
  ent_t             rd_ent;
  ent_t             commit_ent;
  ent_t [N_ENT-1:0] tbl;
  logic [IDX_W-1:0] sel_idx;
  logic             commit;
  logic [31:0]      cmd_q, d1_q, d2_q;
  logic [N_ENT-1:0] win_vec;

  rsm_regs #(.N_ENT(N_ENT)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_ent(rd_ent), .sel_idx(sel_idx),
    .commit(commit), .commit_ent(commit_ent),
    .cmd_q(cmd_q), .d1_q(d1_q), .d2_q(d2_q)
  );

  rsm_store #(.N_ENT(N_ENT)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_idx(sel_idx),
    .wr_ent(commit_ent), .rd_idx(sel_idx), .rd_ent(rd_ent), .tbl(tbl)
  );

  rsm_match #(.N_ENT(N_ENT)) u_match (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_rid(lk_rid),
    .tbl(tbl), .win_vec(win_vec), .out_valid(lk_out_valid),
    .hit(lk_hit), .sid(lk_sid), .cid(lk_cid)
  );

  always_comb begin
    case (reg_raddr)
      ADR_CMD: reg_rdata = cmd_q;
      ADR_D1:  reg_rdata = d1_q;
      ADR_D2:  reg_rdata = d2_q;
      default: reg_rdata = '0;
    endcase
  end

  assign lk_msi_sid = lk_hit ? {MSI_SRC, lk_sid} : 8'h00;
endmodule

// File: rtl/rid_sid_map_chk.sv
module rid_sid_map_chk #(
  parameter int         N_ENT   = 32,
  parameter logic [1:0] MSI_SRC = 2'b01
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      cmd_q,
  input logic             lk_valid,
  input logic             lk_out_valid,
  input logic             lk_hit,
  input logic [5:0]       lk_sid,
  input logic [2:0]       lk_cid,
  input logic [7:0]       lk_msi_sid,
  input logic [N_ENT-1:0] win_vec
);
  assert_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_out_valid);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_out_valid);

  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_sid == 6'd0 && lk_cid == 3'd0));

  assert_hit_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_out_valid);

  assert_one_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec));

  assert_msi_tag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_msi_sid[7:6] == MSI_SRC));

  assert_msi_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_msi_sid == 8'h00));

  assert_cmd_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0) |=>
      (cmd_q[16] == $past(reg_wdata[16]) && cmd_q[4:0] == $past(reg_wdata[4:0])));
endmodule

bind rid_sid_map rid_sid_map_chk #(.N_ENT(N_ENT), .MSI_SRC(MSI_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cmd_q(cmd_q), .lk_valid(lk_valid),
  .lk_out_valid(lk_out_valid), .lk_hit(lk_hit), .lk_sid(lk_sid),
  .lk_cid(lk_cid), .lk_msi_sid(lk_msi_sid), .win_vec(win_vec)
);

// File: tb/rid_sid_map_tb.sv
`timescale 1ns/1ps
module rid_sid_map_tb;
  localparam logic [1:0] MSI = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [1:0]  reg_raddr = 2'd0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_rid = 16'd0;
  logic        lk_out_valid, lk_hit;
  logic [5:0]  lk_sid;
  logic [2:0]  lk_cid;
  logic [7:0]  lk_msi_sid;

  int n_tests = 0;
  int n_fail  = 0;

  logic        m_vld [32];
  logic [2:0]  m_cid [32];
  logic [5:0]  m_sid [32];
  logic [15:0] m_rid [32];
  logic [15:0] m_msk [32];
  logic [31:0] m_d1, m_d2;

  always #10 clk = ~clk;

  rid_sid_map #(.N_ENT(32), .MSI_SRC(MSI)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_rid(lk_rid), .lk_out_valid(lk_out_valid),
    .lk_hit(lk_hit), .lk_sid(lk_sid), .lk_cid(lk_cid), .lk_msi_sid(lk_msi_sid)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected result word {out_valid, hit, cid, msi[7:0], sid}
  function automatic logic [18:0] model_lookup(logic [15:0] rid);
    for (int i = 0; i < 32; i++) begin
      if (m_vld[i] && ((rid & m_msk[i]) == (m_rid[i] & m_msk[i])))
        return {1'b1, 1'b1, m_cid[i], MSI, m_sid[i], m_sid[i]};
    end
    return {1'b1, 1'b0, 3'd0, 8'd0, 6'd0};
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(string req, logic [1:0] a, logic [31:0] exp);
    reg_raddr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic stage(logic v, logic [2:0] c, logic [5:0] s, logic [15:0] r, logic [15:0] m);
    m_d1 = {v, 20'd0, c, 2'd0, s};
    m_d2 = {r, m};
    wr(2'd1, m_d1);
    wr(2'd2, m_d2);
  endtask

  task automatic model_commit(int idx);
    m_vld[idx] = m_d1[31]; m_cid[idx] = m_d1[10:8]; m_sid[idx] = m_d1[5:0];
    m_rid[idx] = m_d2[31:16]; m_msk[idx] = m_d2[15:0];
  endtask

  task automatic add(int idx, logic v, logic [2:0] c, logic [5:0] s, logic [15:0] r, logic [15:0] m);
    stage(v, c, s, r, m);
    wr(2'd0, 32'(idx) & 32'h1F);
    model_commit(idx);
  endtask

  task automatic look(string req, logic [15:0] rid);
    logic [18:0] exp;
    exp = model_lookup(rid);
    @(negedge clk);
    lk_valid = 1'b1; lk_rid = rid;
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, 32'({lk_out_valid, lk_hit, lk_cid, lk_msi_sid, lk_sid}), 32'(exp));
  endtask

  initial begin
    #(20ns * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] masks [3];
    masks[0] = 16'hFFFF; masks[1] = 16'hFFF0; masks[2] = 16'hFF00;
    for (int i = 0; i < 32; i++) begin
      m_vld[i] = 1'b0; m_cid[i] = '0; m_sid[i] = '0; m_rid[i] = '0; m_msk[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd("R1 cmd", 2'd0, 32'd0);
    rd("R1 d1", 2'd1, 32'd0);
    rd("R1 d2", 2'd2, 32'd0);
    look("R1 empty table", 16'h0000);

    // R2: staging field masking
    wr(2'd1, 32'hFFFF_FFFF);
    rd("R2 d1 mask", 2'd1, 32'h8000_073F);
    wr(2'd2, 32'h1234_5678);
    rd("R2 d2 full", 2'd2, 32'h1234_5678);

    // R3 / R4: commit and read back
    add(3, 1'b1, 3'd2, 6'd5, 16'h0100, 16'hFFFF);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    wr(2'd0, 32'hFFFF_0003);
    rd("R4 cmd readback", 2'd0, 32'h0001_0003);
    rd("R3 d1 from slot", 2'd1, 32'h8000_0205);
    rd("R3 d2 from slot", 2'd2, 32'h0100_FFFF);

    // R5 / R11: exact hit
    look("R5 exact hit", 16'h0100);
    look("R6 full mask one bit off", 16'h0101);

    // R6: partial mask
    add(7, 1'b1, 3'd1, 6'd9, 16'h0200, 16'hFF00);
    look("R6 masked hit", 16'h02AB);
    look("R6 masked miss", 16'h03AB);

    // R7: lower slot wins
    add(1, 1'b1, 3'd4, 6'd12, 16'h0200, 16'hFFF0);
    look("R7 low slot wins", 16'h0205);
    look("R7 fallback to higher slot", 16'h02AB);

    // R10: commit and lookup on the same edge
    stage(1'b1, 3'd3, 6'd20, 16'h0300, 16'hFFFF);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd0;
    lk_valid = 1'b1; lk_rid = 16'h0300;
    @(negedge clk);
    reg_we = 1'b0; lk_valid = 1'b0;
    check("R10 same edge sees old table",
          32'({lk_out_valid, lk_hit, lk_cid, lk_msi_sid, lk_sid}),
          32'(model_lookup(16'h0300)));
    model_commit(0);
    look("R10 next edge sees new entry", 16'h0300);

    // R12: invalidate slot 3
    add(3, 1'b0, 3'd0, 6'd0, 16'h0000, 16'h0000);
    look("R12 invalidated miss", 16'h0100);
    wr(2'd0, 32'h0001_0003);
    rd("R12 slot reads zero", 2'd1, 32'd0);

    // R8: idle cycle output
    @(negedge clk);
    check("R8 idle outputs", 32'({lk_out_valid, lk_hit, lk_sid, lk_cid, lk_msi_sid}), 32'd0);

    // random mix (R5 R6 R7 R8 R11)
    void'($urandom(32'h5EED_0042));
    for (int it = 0; it < 300; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        add($urandom_range(0, 31), ($urandom_range(0, 4) != 0),
            3'($urandom), 6'($urandom), 16'h0A00 | 16'($urandom_range(0, 31)),
            masks[$urandom_range(0, 2)]);
      end else begin
        look("R5 random lookup", 16'h0A00 | 16'($urandom_range(0, 31)));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule